// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs a successive-approximation converter through a sequence of conversions and files each result in a small bank of result slots. An 8-bit control word sets the channel plan (one channel or a walk across channels), whether sequences repeat, and how each 10-bit code is laid out in its 16-bit slot: left-aligned unsigned, left-aligned two's complement, or right-aligned unsigned. A separate 4-bit input sets how many conversions make up one sequence.

The converter itself sits outside. For each conversion the controller sends a one-cycle start pulse together with a channel index. The converter answers with a one-cycle done pulse and the 10-bit code. At most one conversion is outstanding at a time. Any write of the control word stops the sequence in progress and starts a fresh one with the new settings. A conversion that was in flight at that moment is allowed to finish, and its code is thrown away. A completion flag reports that a sequence has ended. The result slots are read through a registered read port that has one cycle of latency.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, the completion flag is 0, and no start pulse is issued until the control word is written.
- R2: A control write aborts the running sequence and starts a new one with the new settings. A conversion in flight at that moment is waited out, and its code is written to no slot.
- R3: With the repeat bit (bit 5) at 0, exactly one sequence of N conversions runs, the completion flag then rises, and no further start pulse follows.
- R4: With the repeat bit at 1, sequences follow one another without end, each starting again at the programmed channel. The completion flag stays at 1 once the first sequence has ended.
- R5: With the multi-channel bit (bit 4) at 0, every conversion uses the channel given in bits 3:0.
- R6: With the multi-channel bit at 1, conversion k uses channel (start + k) mod 16, so the channel after 15 is 0.
- R7: The sequence length N is the 4-bit length input when it is 1 to 8, and 8 when it is 0. Slot k holds the result of conversion k of the sequence.
- R8: With the justify bit (bit 7) at 1, a slot holds {6'b0, code}, and the signed bit has no effect.
- R9: With the justify bit at 0 and the signed bit (bit 6) at 0, a slot holds {code, 6'b0}.
- R10: With the justify bit at 0 and the signed bit at 1, a slot holds {~code[9], code[8:0], 6'b0}, so mid-scale 512 maps to 0.
- R11: A start pulse lasts one cycle, and no new start is issued while a conversion is outstanding.
- R12: A control write clears the completion flag on the following cycle.
- R13: The slot read port returns the slot selected on one cycle one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: justify, signed, repeat, multi, channel[3:0] |
| seq_len | input | 4 | Conversions per sequence, 0 means 8 |
| cfg_q | output | 8 | Current control word |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | 4 | Channel for the conversion being started |
| conv_done | input | 1 | One-cycle completion from the converter |
| conv_code | input | 10 | Conversion code, valid with conv_done |
| seq_done | output | 1 | Sequence completion flag |
| rd_slot | input | 3 | Result slot to read |
| rd_data | output | 16 | Result slot contents, one cycle after rd_slot |

## Verification
The bench sweeps every format mode against both channel plans, four start channels that include the wrap from 15, and lengths 0, 1, 3 and 8. A design that mishandled the wrap would issue channel 16 or hold at 15, and one that read length 0 literally would run no conversions or the wrong count. An abort is forced while a conversion is in flight. The slot behind the aborted conversion must still hold the value from an earlier sequence, so a controller that stored the late code, or that restarted before the old conversion finished, is caught. A repeating sequence is checked for restarting at the programmed channel, not at the channel where the last sequence stopped, and for keeping its completion flag set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_BITS = 4;

  typedef struct packed {
    logic                justify;
    logic                sgn;
    logic                rpt;
    logic                multi;
    logic [CH_BITS-1:0]  ch;
  } ctl_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DRAIN = 2'd3
  } seq_state_t;
endpackage

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int CODE_W = 10,
  parameter int RES_W  = 16
) (
  input  logic              justify,
  input  logic              sgn,
  input  logic [CODE_W-1:0] code,
  output logic [RES_W-1:0]  res
);
  localparam int PAD = RES_W - CODE_W;

  always_comb begin
    if (justify)
      res = {{PAD{1'b0}}, code};
    else if (sgn)
      res = {~code[CODE_W-1], code[CODE_W-2:0], {PAD{1'b0}}};
    else
      res = {code, {PAD{1'b0}}};
  end
endmodule

// File: rtl/adc_slot_ram.sv
module adc_slot_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm import adc_seq_pkg::*; #(
  parameter int NUM_CH    = 16,
  parameter int MAX_SLOTS = 8,
  parameter int LEN_W     = 4,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CH_BITS-1:0] new_ch,
  input  ctl_t               ctl_q,
  input  logic [LEN_W-1:0]   seq_len,
  input  logic               conv_done,
  output logic               conv_start,
  output logic [CH_BITS-1:0] conv_ch,
  output logic               wr_en,
  output logic [SLOT_W-1:0]  wr_slot,
  output logic               seq_done
);
  localparam logic [LEN_W-1:0]   MAXL   = LEN_W'(MAX_SLOTS);
  localparam logic [CH_BITS-1:0] LAST_CH = CH_BITS'(NUM_CH - 1);

  seq_state_t         state;
  logic [LEN_W-1:0]   idx;
  logic [LEN_W-1:0]   len_q;
  logic [CH_BITS-1:0] ch_q;
  logic               busy;

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    if (l == '0 || l > MAXL) return MAXL;
    return l;
  endfunction

  assign busy = (state == S_WAIT) || (state == S_DRAIN);

  always_ff @(posedge clk) begin
    conv_start <= 1'b0;
    wr_en      <= 1'b0;
    if (rst) begin
      state    <= S_IDLE;
      idx      <= '0;
      len_q    <= MAXL;
      ch_q     <= '0;
      conv_ch  <= '0;
      wr_slot  <= '0;
      seq_done <= 1'b0;
    end else if (cfg_we) begin
      seq_done <= 1'b0;
      idx      <= '0;
      len_q    <= eff_len(seq_len);
      ch_q     <= new_ch;
      state    <= (busy && !conv_done) ? S_DRAIN : S_ISSUE;
    end else begin
      case (state)
        S_ISSUE: begin
          conv_start <= 1'b1;
          conv_ch    <= ch_q;
          state      <= S_WAIT;
        end
        S_DRAIN: begin
          if (conv_done) state <= S_ISSUE;
        end
        S_WAIT: begin
          if (conv_done) begin
            wr_en   <= 1'b1;
            wr_slot <= idx[SLOT_W-1:0];
            if (idx == len_q - 1'b1) begin
              seq_done <= 1'b1;
              if (ctl_q.rpt) begin
                idx   <= '0;
                ch_q  <= ctl_q.ch;
                len_q <= eff_len(seq_len);
                state <= S_ISSUE;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              idx <= idx + 1'b1;
              if (ctl_q.multi)
                ch_q <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
              state <= S_ISSUE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R11

  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !seq_done); // R12

  AST_NO_WRITE_WHEN_DRAINING: assert property (@(posedge clk) disable iff (rst)
    (state == S_DRAIN) |=> !wr_en); // R2
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int CODE_W    = 10,
  parameter int RES_W     = 16,
  parameter int NUM_CH    = 16,
  parameter int MAX_SLOTS = 8,
  parameter int LEN_W     = 4,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  input  logic [LEN_W-1:0]   seq_len,
  output logic [7:0]         cfg_q,
  output logic               conv_start,
  output logic [CH_BITS-1:0] conv_ch,
  input  logic               conv_done,
  input  logic [CODE_W-1:0]  conv_code,
  output logic               seq_done,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [RES_W-1:0]   rd_data
);
  ctl_t              ctl_q;
  ctl_t              ctl_in;
  logic              wr_en;
  logic [SLOT_W-1:0] wr_slot;
  logic [RES_W-1:0]  fmt_res;
  logic [RES_W-1:0]  wr_data_q;

  assign ctl_in = ctl_t'(cfg_wdata);
  assign cfg_q  = ctl_q;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (cfg_we) ctl_q <= ctl_in;
  end

  adc_seq_fsm #(
    .NUM_CH(NUM_CH), .MAX_SLOTS(MAX_SLOTS), .LEN_W(LEN_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .new_ch(ctl_in.ch),
    .ctl_q(ctl_q), .seq_len(seq_len), .conv_done(conv_done),
    .conv_start(conv_start), .conv_ch(conv_ch),
    .wr_en(wr_en), .wr_slot(wr_slot), .seq_done(seq_done)
  );

  adc_res_fmt #(.CODE_W(CODE_W), .RES_W(RES_W)) fmt_i (
    .justify(ctl_q.justify), .sgn(ctl_q.sgn), .code(conv_code), .res(fmt_res)
  );

  always_ff @(posedge clk) begin
    if (conv_done) wr_data_q <= fmt_res;
  end

  adc_slot_ram #(.DW(RES_W), .DEPTH(MAX_SLOTS)) ram_i (
    .clk(clk), .we(wr_en), .waddr(wr_slot), .wdata(wr_data_q),
    .raddr(rd_slot), .rdata(rd_data)
  );

  AST_SINGLE_CH: assert property (@(posedge clk) disable iff (rst)
    (conv_start && !ctl_q.multi) |-> (conv_ch == ctl_q.ch)); // R5

  AST_STOP_AFTER_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (seq_done && !ctl_q.rpt) |-> !conv_start); // R3

  AST_RJ_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ctl_q.justify) |-> (wr_data_q[RES_W-1:CODE_W] == '0)); // R8

  AST_LJ_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ctl_q.justify) |-> (wr_data_q[RES_W-CODE_W-1:0] == '0)); // R9
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  seq_len = '0;
  logic [7:0]  cfg_q;
  logic        conv_start;
  logic [3:0]  conv_ch;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_code = '0;
  logic        seq_done;
  logic [2:0]  rd_slot = '0;
  logic [15:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int seed = 0;
  int starts = 0;
  logic [3:0] ch_hist [0:4095];
  logic       pend = 1'b0;
  int         pend_cnt = 0;
  logic [9:0] pend_code = '0;
  logic       prev_start = 1'b0;
  int         proto_err = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .seq_len(seq_len), .cfg_q(cfg_q), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_code(conv_code),
    .seq_done(seq_done), .rd_slot(rd_slot), .rd_data(rd_data)
  );

  function automatic logic [9:0] mkcode(input int ch, input int sd);
    return 10'((ch * 37 + sd * 101 + 7) % 1024);
  endfunction

  function automatic logic [15:0] fmt(input logic [9:0] c, input bit j, input bit s);
    if (j) return {6'b0, c};
    if (s) return {~c[9], c[8:0], 6'b0};
    return {c, 6'b0};
  endfunction

  // converter model
  always @(posedge clk) begin
    conv_done <= 1'b0;
    prev_start <= conv_start;
    if (!rst) begin
      if (conv_start && prev_start) proto_err <= proto_err + 1;
      if (conv_start) begin
        if (pend) proto_err <= proto_err + 1;
        if (starts < 4096) ch_hist[starts] <= conv_ch;
        starts    <= starts + 1;
        pend      <= 1'b1;
        pend_cnt  <= LAT;
        pend_code <= mkcode(int'(conv_ch), seed);
      end else if (pend) begin
        if (pend_cnt == 1) begin
          conv_done <= 1'b1;
          conv_code <= pend_code;
          pend      <= 1'b0;
        end else begin
          pend_cnt <= pend_cnt - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wdata = v;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!seq_done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(seq_done, req, int'(seq_done), 1);
  endtask

  task automatic read_slot(input int k, output logic [15:0] d);
    @(negedge clk);
    rd_slot = 3'(k);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic run_single(input bit j, input bit s, input bit m,
                            input int ch, input int len, input int sd);
    int base;
    int n;
    logic [15:0] d;
    seed = sd;
    seq_len = 4'(len);
    base = starts;
    wr_cfg({j, s, 1'b0, m, 4'(ch)});
    chk(!seq_done, "R12 flag cleared by write", int'(seq_done), 0);
    chk(cfg_q == {j, s, 1'b0, m, 4'(ch)}, "R2 control word", int'(cfg_q), int'({j, s, 1'b0, m, 4'(ch)}));
    wait_done("R3 sequence completes");
    repeat (20) @(negedge clk);
    n = (len == 0) ? 8 : len;
    chk(starts - base == n, "R3/R7 conversion count", starts - base, n);
    for (int k = 0; k < n; k++) begin
      int ec;
      ec = m ? (ch + k) % 16 : ch;
      chk(ch_hist[base + k] == 4'(ec), m ? "R6 channel step" : "R5 fixed channel",
          int'(ch_hist[base + k]), ec);
      read_slot(k, d);
      chk(d == fmt(mkcode(ec, sd), j, s),
          j ? "R8/R13 slot k right-justified" : (s ? "R10/R13 slot k signed" : "R9/R13 slot k unsigned"),
          int'(d), int'(fmt(mkcode(ec, sd), j, s)));
    end
  endtask

  initial begin
    automatic int chs[4] = '{0, 5, 13, 15};
    automatic int lens[4] = '{0, 1, 3, 8};
    automatic int run = 1;
    int base;
    int t;
    logic [15:0] d;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(cfg_q == 8'h00, "R1 control word reset", int'(cfg_q), 0);
    chk(!seq_done, "R1 flag reset", int'(seq_done), 0);
    chk(starts == 0, "R1 no start before write", starts, 0);

    for (int j = 0; j < 2; j++)
      for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++)
          for (int ci = 0; ci < 4; ci++)
            for (int li = 0; li < 4; li++) begin
              run_single(j[0], s[0], m[0], chs[ci], lens[li], run);
              run++;
            end

    // R2 abort with conversion in flight
    run_single(1'b0, 1'b0, 1'b1, 0, 8, 200);
    seed = 201;
    seq_len = 4'd8;
    base = starts;
    wr_cfg(8'b0001_0000);
    t = 0;
    while (starts < base + 4 && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(starts == base + 4, "R2 reached mid-sequence", starts - base, 4);
    seed = 202;
    seq_len = 4'd2;
    wr_cfg(8'b1000_1001);
    base = starts;
    wait_done("R2 restarted sequence completes");
    repeat (20) @(negedge clk);
    chk(starts - base == 2, "R2 new sequence count", starts - base, 2);
    chk(proto_err == 0, "R11 start pulse and overlap", proto_err, 0);
    read_slot(0, d);
    chk(d == {6'b0, mkcode(9, 202)}, "R2 slot0 new settings", int'(d), int'({6'b0, mkcode(9, 202)}));
    read_slot(1, d);
    chk(d == {6'b0, mkcode(9, 202)}, "R2 slot1 new settings", int'(d), int'({6'b0, mkcode(9, 202)}));
    read_slot(2, d);
    chk(d == {mkcode(2, 201), 6'b0}, "R2 slot2 before abort", int'(d), int'({mkcode(2, 201), 6'b0}));
    read_slot(3, d);
    chk(d == {mkcode(3, 200), 6'b0}, "R2 aborted conversion discarded", int'(d), int'({mkcode(3, 200), 6'b0}));

    // R4 repeating sequence with wrap
    seed = 300;
    seq_len = 4'd3;
    base = starts;
    wr_cfg(8'b0011_1110);
    wait_done("R4 first sequence ends");
    t = 0;
    while (starts < base + 9 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(starts >= base + 9, "R4 sequences continue", starts - base, 9);
    chk(seq_done, "R4 flag held while repeating", int'(seq_done), 1);
    for (int i = 0; i < 9; i++)
      chk(ch_hist[base + i] == 4'((14 + i % 3) % 16), "R4/R6 repeat channel order",
          int'(ch_hist[base + i]), (14 + i % 3) % 16);
    seq_len = 4'd1;
    wr_cfg(8'h05);
    chk(!seq_done, "R12 flag cleared leaving repeat", int'(seq_done), 0);
    wait_done("R3 single after repeat");
    repeat (10) @(negedge clk);
    base = starts;
    repeat (40) @(negedge clk);
    chk(starts == base, "R3 no start after single sequence", starts - base, 0);
    chk(proto_err == 0, "R11 handshake protocol", proto_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule